// File: doc/BRIEF.md
# Split-Aware Fixed-Priority Bus Arbiter

This block is the one central arbiter of a multi-master shared bus. Each master raises a request line. The arbiter hands bus ownership to exactly one master at a time. It drives a one-hot grant vector and the number of the owning master. Selection is by fixed priority: master 0 ranks highest. When no eligible master is requesting, the grant parks on a default master chosen by parameter. Ownership changes only on clock edges where the bus ready signal is high, so an address phase that is waiting on a slow data phase is never disturbed.

A slave can answer a transfer with a split response. When that response completes, the arbiter removes the master that owned the data phase from arbitration and passes the bus to another requester. The removed master stays out until a slave raises that master's bit on the resume vector. The arbiter samples the resume vector on every cycle, whether ready is high or low. A resumed master then competes again under normal priority. It is re-granted only when no higher-ranked eligible master is requesting.

Top module: `split_bus_arbiter`

## Requirements
- R1: During and directly after reset, `grant` is one-hot on master DEF_MST, `owner` equals DEF_MST, and no master is held out.
- R2: `grant` always has exactly one bit set, and that bit is the one at index `owner`.
- R3: On a rising edge with `ready` high, ownership goes to the lowest-numbered master whose `req` bit is set and that is not held out.
- R4: On a rising edge with `ready` low, `grant` and `owner` keep their values.
- R5: On a rising edge with `ready` high and no eligible requester, ownership parks on DEF_MST.
- R6: A split completes on an edge where `resp_split` and `ready` are both high. It holds out the data-phase master, which is the `owner` value captured at the previous ready-high edge. From then on that master's `req` is ignored.
- R7: A set bit i of `split_resume`, seen on any edge, releases master i. The release also applies to the arbitration decision at that same edge.
- R8: A resume bit for a master that is not held out has no effect. If a split completes and that same master's resume bit is high on the same edge, the master stays held out.
- R9: A released master is granted only if no lower-numbered eligible master is requesting.
- R10: On the edge where a split completes, ownership moves to another eligible requester, even if the split master still requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N_MST | Per-master bus request |
| ready | input | 1 | Bus ready; high when the current data phase completes |
| resp_split | input | 1 | Slave is giving a split response to the data-phase master |
| split_resume | input | N_MST | Per-master resume flags from slaves |
| grant | output | N_MST | One-hot bus grant |
| owner | output | $clog2(N_MST) | Number of the master that owns the address phase |

## Verification
The bench attacks the edge where a split completes. It checks that the split master loses the bus at once while it still requests. A design that masked one cycle late would leave it owning the bus. The bench drives a resume and a split for the same master on one edge. A design where resume wins would hand the bus straight back. It also sends a resume while ready is low and checks that the release is kept until the next ready edge. A design that gated resume with ready would keep the master starved. Finally it releases a master while a higher-ranked one requests, which exposes any design that favours resumed masters over priority.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned MAX_MST = 16;
  localparam int unsigned IDX_W   = 4;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // Lowest set bit wins; hit low when the vector is empty.
  function automatic pick_t pick_lowest(input logic [MAX_MST-1:0] v);
    pick_t r;
    r = '0;
    for (int i = MAX_MST - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.hit = 1'b1;
        r.idx = IDX_W'(i);
      end
    end
    return r;
  endfunction

  function automatic logic [MAX_MST-1:0] idx_to_onehot(input logic [IDX_W-1:0] i);
    return MAX_MST'(1) << i;
  endfunction
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N_MST = 4,
  localparam int unsigned MW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] eligible,
  output logic [MW-1:0]    pick_idx,
  output logic             any_hit
);
  import arb_pkg::*;

  pick_t p;

  always_comb begin
    p        = pick_lowest(MAX_MST'(eligible));
    any_hit  = p.hit;
    pick_idx = MW'(p.idx);
  end
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
  parameter int unsigned N_MST = 4,
  localparam int unsigned MW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_done,
  input  logic [MW-1:0]    dp_idx,
  input  logic [N_MST-1:0] resume,
  output logic [N_MST-1:0] mask_q,
  output logic [N_MST-1:0] mask_nx
);
  import arb_pkg::*;

  logic [N_MST-1:0] set_vec;

  always_comb begin
    set_vec = split_done ? N_MST'(idx_to_onehot(IDX_W'(dp_idx))) : '0;
    // A new split for the same master outranks a resume on the same edge.
    mask_nx = (mask_q & ~resume) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nx;
  end
endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter #(
  parameter int unsigned N_MST   = 4,
  parameter int unsigned DEF_MST = 0,
  localparam int unsigned MW     = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req,
  input  logic             ready,
  input  logic             resp_split,
  input  logic [N_MST-1:0] split_resume,
  output logic [N_MST-1:0] grant,
  output logic [MW-1:0]    owner
);
  import arb_pkg::*;

  localparam logic [MW-1:0] DEF_IDX = MW'(DEF_MST);

  logic [MW-1:0]    owner_q;
  logic [MW-1:0]    dp_q;
  logic [N_MST-1:0] grant_q;
  logic [N_MST-1:0] mask_q;
  logic [N_MST-1:0] mask_nx;
  logic [N_MST-1:0] eligible;
  logic [MW-1:0]    pick_idx;
  logic             any_hit;
  logic [MW-1:0]    win_idx;
  logic             split_done;

  assign split_done = resp_split & ready;

  arb_split_mask #(.N_MST(N_MST)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .split_done (split_done),
    .dp_idx     (dp_q),
    .resume     (split_resume),
    .mask_q     (mask_q),
    .mask_nx    (mask_nx)
  );

  assign eligible = req & ~mask_nx;

  arb_prio_pick #(.N_MST(N_MST)) u_pick (
    .eligible (eligible),
    .pick_idx (pick_idx),
    .any_hit  (any_hit)
  );

  assign win_idx = any_hit ? pick_idx : DEF_IDX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= DEF_IDX;
      dp_q    <= DEF_IDX;
      grant_q <= N_MST'(idx_to_onehot(IDX_W'(DEF_IDX)));
    end else if (ready) begin
      owner_q <= win_idx;
      dp_q    <= owner_q;
      grant_q <= N_MST'(idx_to_onehot(IDX_W'(win_idx)));
    end
  end

  assign grant = grant_q;
  assign owner = owner_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned N_MST   = 4,
  parameter int unsigned DEF_MST = 0,
  localparam int unsigned MW     = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             resp_split,
  input logic [N_MST-1:0] split_resume,
  input logic [N_MST-1:0] grant,
  input logic [MW-1:0]    owner,
  input logic [N_MST-1:0] mask_q,
  input logic [MW-1:0]    dp_q,
  input logic             any_hit
);
  logic chk_split;
  assign chk_split = resp_split && ready;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1); // R2
  AST_OWNER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant[owner]); // R2
  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(grant) && $stable(owner)); // R4
  AST_PARK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !any_hit |=> owner == MW'(DEF_MST)); // R5
  AST_SPLIT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_split |=> mask_q[$past(dp_q)]); // R6
  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[owner] |-> owner == MW'(DEF_MST)); // R10

  for (genvar i = 0; i < N_MST; i++) begin : g_res
    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      split_resume[i] && !(chk_split && dp_q == MW'(i)) |=> !mask_q[i]); // R7
  end
endmodule

bind split_bus_arbiter arb_checker #(.N_MST(N_MST), .DEF_MST(DEF_MST)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ready        (ready),
  .resp_split   (resp_split),
  .split_resume (split_resume),
  .grant        (grant),
  .owner        (owner),
  .mask_q       (mask_q),
  .dp_q         (dp_q),
  .any_hit      (any_hit)
);

// File: tb/test_split_bus_arbiter.sv
`timescale 1ns/1ps
module test_split_bus_arbiter;
  localparam int N = 4;
  localparam int DEF = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         ready;
  logic         resp_split;
  logic [N-1:0] split_resume;
  logic [N-1:0] grant;
  logic [1:0]   owner;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  split_bus_arbiter #(.N_MST(N), .DEF_MST(DEF)) i_split_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready),
    .resp_split(resp_split), .split_resume(split_resume),
    .grant(grant), .owner(owner)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Checks owner and that grant is the matching one-hot (R2).
  task automatic expect_owner(string tag, int exp);
    n_vec++;
    if (int'(owner) != exp) begin
      n_bad++;
      $display("FAIL %s owner act=%0d exp=%0d", tag, owner, exp);
    end
    n_vec++;
    if (grant != N'(1 << exp)) begin
      n_bad++;
      $display("FAIL %s/R2 grant act=%b exp=%b", tag, grant, N'(1 << exp));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = '0; ready = 1'b1; resp_split = 1'b0; split_resume = '0;
    repeat (3) step();
    expect_owner("R1 in reset", DEF);
    rst_n = 1'b1;
    #1;
    expect_owner("R1 after reset", DEF);
  endtask

  task automatic t_priority();
    req = 4'b1010; step(); expect_owner("R3 1010", 1);
    req = 4'b1000; step(); expect_owner("R3 1000", 3);
    req = 4'b0110; step(); expect_owner("R3 0110", 1);
  endtask

  task automatic t_hold();
    ready = 1'b0; req = 4'b0001;
    step(); expect_owner("R4 hold a", 1);
    step(); expect_owner("R4 hold b", 1);
    ready = 1'b1;
    step(); expect_owner("R3 after hold", 0);
  endtask

  task automatic t_park();
    req = '0; step(); expect_owner("R5 park", DEF);
  endtask

  task automatic t_split();
    req = 4'b0010; step(); expect_owner("R3 m1 addr", 1);
    step(); expect_owner("R3 m1 data", 1);
    req = 4'b1010; resp_split = 1'b1;
    step(); expect_owner("R10 handoff", 3);
    resp_split = 1'b0;
    step(); expect_owner("R6 m1 ignored", 3);
    req = 4'b0010;
    step(); expect_owner("R6 m1 alone parks", DEF);
    split_resume = 4'b1000;
    step(); expect_owner("R8 resume unmasked", DEF);
    split_resume = 4'b0010; req = 4'b0011;
    step(); expect_owner("R9 higher wins", 0);
    split_resume = '0; req = 4'b0010;
    step(); expect_owner("R7 released", 1);
  endtask

  task automatic t_collide();
    req = 4'b0010; step(); expect_owner("R3 m1 again", 1);
    resp_split = 1'b1; split_resume = 4'b0010;
    step(); expect_owner("R8 set wins", DEF);
    resp_split = 1'b0; ready = 1'b0;
    step(); expect_owner("R4 resume not ready", DEF);
    split_resume = '0; ready = 1'b1;
    step(); expect_owner("R7 resume kept", 1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_priority();
    t_hold();
    t_park();
    t_split();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule